// File: doc/BRIEF.md
# Burst Column Order Generator

This block sequences the column words of one memory burst. A command gives a starting column, a read or write direction and a per-command chop request. The block then produces one column index on each following clock, along with a valid flag and a last-beat flag. A device model or controller uses this order to steer data words into or out of the array. The configuration decides how the burst is ordered and how long it is. Reads wrap inside a group of four columns (sequential) or walk an XOR pattern (interleaved). Writes always run upward from column zero. A four-beat chop keeps only the first half of the eight-beat order.

The block also emits a one-cycle write-recovery marker for every write. It is the reference point from which write-recovery and write-to-read spacing are counted. When the configuration fixes every burst at four beats, the marker comes two cycles earlier than for an eight-beat write. When the chop is requested per command, the marker stays where the eight-beat write would put it.

Top module: `burst_order_gen`

## Requirements
- R1: While reset is held and on the first cycle after it, beat_valid, beat_last and wr_rec_mark are 0 and cmd_ready is 1.
- R2: If a command is accepted in cycle k, beats 0..L-1 appear in cycles k+1..k+L with beat_valid 1 and no gap. beat_last is 1 only on beat L-1. beat_col reads 0 whenever beat_valid is 0.
- R3: The burst length L comes from cfg_bmode. 2'b00 gives 8. 2'b10 gives 4. 2'b11 is treated as 2'b00. 2'b01 gives 4 when cmd_chop is 1 and 8 when cmd_chop is 0.
- R4: With cfg_interleave 0, a read starting at column s puts out on beat i the column whose bit 2 is s[2]^i[2] and whose bits 1:0 are (s[1:0]+i[1:0]) mod 4.
- R5: With cfg_interleave 1, a read starting at column s puts out s XOR i on beat i.
- R6: A write puts out column i on beat i, whatever cmd_col and cfg_interleave are.
- R7: cmd_ready is 1 when no burst is running or when the current beat is the last one. A cmd_valid raised while cmd_ready is 0 has no effect: the running burst continues unchanged and no burst or marker follows from it.
- R8: A command accepted on the last beat of a burst makes its beat 0 appear in the very next cycle.
- R9: A write accepted in cycle k under cfg_bmode 2'b00, 2'b01 or 2'b11 pulses wr_rec_mark for one cycle in cycle k+9. This holds for on-the-fly chops too.
- R10: A write accepted in cycle k under cfg_bmode 2'b10 pulses wr_rec_mark for one cycle in cycle k+7.
- R11: Reads never pulse wr_rec_mark.
- R12: Ordering, direction and length are captured when the command is accepted. Changing cfg_bmode or cfg_interleave during a burst does not alter it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_bmode | input | 2 | Burst length setting: 00 eight, 01 per command, 10 four, 11 as 00 |
| cfg_interleave | input | 1 | 0 sequential ordering, 1 interleaved ordering |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_write | input | 1 | 1 write, 0 read |
| cmd_chop | input | 1 | Per-command four-beat request (used in mode 01) |
| cmd_col | input | 3 | Starting column, low three bits |
| cmd_ready | output | 1 | Command is taken this cycle if cmd_valid is 1 |
| beat_valid | output | 1 | A beat is being transferred |
| beat_col | output | 3 | Column index of the current beat |
| beat_last | output | 1 | Final beat of the burst |
| wr_rec_mark | output | 1 | One-cycle write-recovery start marker |

## Verification
Each output has a fixed delay from the acceptance cycle k. Beat i is due in cycle k+1+i. The last flag is due on cycle k+4 or k+8. The marker is due on cycle k+9, or on k+7 under fixed chop. cmd_ready is combinational and holds in the acceptance cycle itself. The bench drives and samples on the falling edge. It counts falling edges from the acceptance edge and compares all four outputs at each count through k+11, so an early, late or duplicated beat or marker shows up as a mismatch. It sweeps every mode, ordering, direction, chop bit and start column, then covers back-to-back commands, a command refused while busy, and a configuration change during a burst.

// File: rtl/burst_pkg.sv
package burst_pkg;

    typedef enum logic [1:0] {
        BMODE_FULL = 2'b00,
        BMODE_OTF  = 2'b01,
        BMODE_HALF = 2'b10,
        BMODE_RSVD = 2'b11
    } bmode_e;

    // Per-command chop decision from the configured length setting
    function automatic logic half_burst(input bmode_e mode, input logic chop_req);
        return (mode == BMODE_HALF) || ((mode == BMODE_OTF) && chop_req);
    endfunction

    // Fixed half setting pulls the recovery marker in
    function automatic logic early_mark(input bmode_e mode);
        return mode == BMODE_HALF;
    endfunction

endpackage

// File: rtl/burst_beat_ctrl.sv
module burst_beat_ctrl
    import burst_pkg::*;
#(
    parameter int BEATS = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [1:0]               cfg_bmode,
    input  logic                     cfg_interleave,
    input  logic                     cmd_valid,
    input  logic                     cmd_write,
    input  logic                     cmd_chop,
    input  logic [$clog2(BEATS)-1:0] cmd_col,
    output logic                     act_o,
    output logic [$clog2(BEATS)-1:0] idx_o,
    output logic [$clog2(BEATS)-1:0] start_o,
    output logic                     ilv_o,
    output logic                     wr_o,
    output logic                     last_o,
    output logic                     ready_o,
    output logic                     acc_wr_o,
    output logic                     acc_early_o
);

    localparam int IDX_W     = $clog2(BEATS);
    localparam int FULL_LAST = BEATS - 1;
    localparam int HALF_LAST = BEATS / 2 - 1;

    typedef struct packed {
        logic             act;
        logic [IDX_W-1:0] idx;
        logic [IDX_W-1:0] start;
        logic             ilv;
        logic             wr;
        logic             half;
    } beat_st_t;

    beat_st_t st_d, st_q;
    logic     last_w, ready_w, accept_w;
    bmode_e   mode_w;

    assign mode_w   = bmode_e'(cfg_bmode);
    assign last_w   = st_q.act &&
                      (st_q.idx == (st_q.half ? IDX_W'(HALF_LAST) : IDX_W'(FULL_LAST)));
    assign ready_w  = !st_q.act || last_w;
    assign accept_w = cmd_valid && ready_w;

    always_comb begin
        st_d = st_q;
        if (accept_w) begin
            st_d.act   = 1'b1;
            st_d.idx   = '0;
            st_d.start = cmd_col;
            st_d.ilv   = cfg_interleave;
            st_d.wr    = cmd_write;
            st_d.half  = half_burst(mode_w, cmd_chop);
        end else if (last_w) begin
            st_d.act = 1'b0;
        end else if (st_q.act) begin
            st_d.idx = st_q.idx + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign act_o       = st_q.act;
    assign idx_o       = st_q.idx;
    assign start_o     = st_q.start;
    assign ilv_o       = st_q.ilv;
    assign wr_o        = st_q.wr;
    assign last_o      = last_w;
    assign ready_o     = ready_w;
    assign acc_wr_o    = accept_w && cmd_write;
    assign acc_early_o = early_mark(mode_w);

    // R2
    beat_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.act && !last_w) |=> (st_q.act && st_q.idx == IDX_W'($past(st_q.idx) + 1'b1)));

    // R7
    idle_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !st_q.act |-> ready_o);

    // R8
    chain_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (last_w && cmd_valid) |=> (st_q.act && st_q.idx == '0));

endmodule

// File: rtl/burst_col_map.sv
module burst_col_map #(
    parameter int BEATS = 8
) (
    input  logic                     act_i,
    input  logic [$clog2(BEATS)-1:0] idx_i,
    input  logic [$clog2(BEATS)-1:0] start_i,
    input  logic                     ilv_i,
    input  logic                     wr_i,
    output logic [$clog2(BEATS)-1:0] col_o
);

    localparam int IDX_W = $clog2(BEATS);
    localparam int LOW_W = IDX_W - 1;

    logic [LOW_W-1:0] wrap_w;

    assign wrap_w = start_i[LOW_W-1:0] + idx_i[LOW_W-1:0];

    always_comb begin
        if (!act_i) begin
            col_o = '0;
        end else if (wr_i) begin
            col_o = idx_i;
        end else if (ilv_i) begin
            col_o = start_i ^ idx_i;
        end else begin
            col_o = {start_i[IDX_W-1] ^ idx_i[IDX_W-1], wrap_w};
        end
    end

endmodule

// File: rtl/burst_wr_mark.sv
module burst_wr_mark #(
    parameter int BEATS = 8,
    parameter int EARLY = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic acc_wr_i,
    input  logic acc_early_i,
    output logic mark_o
);

    localparam int DLY_LONG  = BEATS + 1;
    localparam int DLY_SHORT = DLY_LONG - EARLY;

    typedef struct packed {
        logic [DLY_LONG-1:0]  long_sr;
        logic [DLY_SHORT-1:0] short_sr;
    } mark_st_t;

    mark_st_t st_d, st_q;

    always_comb begin
        st_d.long_sr  = {st_q.long_sr[DLY_LONG-2:0], acc_wr_i && !acc_early_i};
        st_d.short_sr = {st_q.short_sr[DLY_SHORT-2:0], acc_wr_i && acc_early_i};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign mark_o = st_q.long_sr[DLY_LONG-1] | st_q.short_sr[DLY_SHORT-1];

    // R9
    mark_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mark_o |=> !mark_o);

endmodule

// File: rtl/burst_order_gen.sv
module burst_order_gen #(
    parameter int BEATS = 8,
    parameter int EARLY = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [1:0]               cfg_bmode,
    input  logic                     cfg_interleave,
    input  logic                     cmd_valid,
    input  logic                     cmd_write,
    input  logic                     cmd_chop,
    input  logic [$clog2(BEATS)-1:0] cmd_col,
    output logic                     cmd_ready,
    output logic                     beat_valid,
    output logic [$clog2(BEATS)-1:0] beat_col,
    output logic                     beat_last,
    output logic                     wr_rec_mark
);

    localparam int IDX_W = $clog2(BEATS);

    logic             act_w, ilv_w, wr_w, acc_wr_w, acc_early_w;
    logic [IDX_W-1:0] idx_w, start_w;

    burst_beat_ctrl #(.BEATS(BEATS)) u_ctrl (
        .clk            (clk),
        .rst_n          (rst_n),
        .cfg_bmode      (cfg_bmode),
        .cfg_interleave (cfg_interleave),
        .cmd_valid      (cmd_valid),
        .cmd_write      (cmd_write),
        .cmd_chop       (cmd_chop),
        .cmd_col        (cmd_col),
        .act_o          (act_w),
        .idx_o          (idx_w),
        .start_o        (start_w),
        .ilv_o          (ilv_w),
        .wr_o           (wr_w),
        .last_o         (beat_last),
        .ready_o        (cmd_ready),
        .acc_wr_o       (acc_wr_w),
        .acc_early_o    (acc_early_w)
    );

    burst_col_map #(.BEATS(BEATS)) u_map (
        .act_i   (act_w),
        .idx_i   (idx_w),
        .start_i (start_w),
        .ilv_i   (ilv_w),
        .wr_i    (wr_w),
        .col_o   (beat_col)
    );

    burst_wr_mark #(.BEATS(BEATS), .EARLY(EARLY)) u_mark (
        .clk         (clk),
        .rst_n       (rst_n),
        .acc_wr_i    (acc_wr_w),
        .acc_early_i (acc_early_w),
        .mark_o      (wr_rec_mark)
    );

    assign beat_valid = act_w;

    // R2
    last_in_burst_chk: assert property (@(posedge clk) disable iff (!rst_n)
        beat_last |-> beat_valid);

endmodule

// File: tb/tb_burst_order_gen.sv
module tb_burst_order_gen;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] cfg_bmode = 2'b00;
    logic       cfg_interleave = 1'b0;
    logic       cmd_valid = 1'b0;
    logic       cmd_write = 1'b0;
    logic       cmd_chop = 1'b0;
    logic [2:0] cmd_col = 3'd0;
    logic       cmd_ready, beat_valid, beat_last, wr_rec_mark;
    logic [2:0] beat_col;

    int n_chk = 0;
    int n_bad = 0;

    always #5ns clk = ~clk;

    burst_order_gen dut (
        .clk(clk), .rst_n(rst_n), .cfg_bmode(cfg_bmode), .cfg_interleave(cfg_interleave),
        .cmd_valid(cmd_valid), .cmd_write(cmd_write), .cmd_chop(cmd_chop), .cmd_col(cmd_col),
        .cmd_ready(cmd_ready), .beat_valid(beat_valid), .beat_col(beat_col),
        .beat_last(beat_last), .wr_rec_mark(wr_rec_mark)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    function automatic int exp_col(input int s, input int i, input bit ilv, input bit wr);
        if (wr) return i;
        if (ilv) return s ^ i;
        return ((s & 4) ^ (i & 4)) | ((s + i) & 3);
    endfunction

    // Compare all outputs at falling edge t after the acceptance edge
    task automatic cmp_beat(input int t, input int len, input int s, input bit ilv,
                            input bit wr, input int mk);
        bit ev = (t >= 1) && (t <= len);
        check(beat_valid == ev, "R2/R3 valid", beat_valid, ev);
        check(beat_last == (t == len), "R2 last", beat_last, t == len);
        if (ev)
            check(beat_col == exp_col(s, t - 1, ilv, wr),
                  wr ? "R6 col" : (ilv ? "R5 col" : "R4 col"), beat_col, exp_col(s, t - 1, ilv, wr));
        else
            check(beat_col == 0, "R2 idle col", beat_col, 0);
        check(wr_rec_mark == (t == mk), wr ? (mk == 7 ? "R10 mark" : "R9 mark") : "R11 mark",
              wr_rec_mark, t == mk);
    endtask

    task automatic run_cmd(input bit [1:0] mode, input bit ilv, input bit wr,
                           input bit chop, input int col);
        int len = (mode == 2'b10 || (mode == 2'b01 && chop)) ? 4 : 8;
        int mk  = !wr ? -1 : ((mode == 2'b10) ? 7 : 9);
        @(negedge clk);
        cfg_bmode = mode; cfg_interleave = ilv;
        cmd_valid = 1'b1; cmd_write = wr; cmd_chop = chop; cmd_col = col[2:0];
        check(cmd_ready == 1'b1, "R7 ready idle", cmd_ready, 1);
        for (int t = 1; t <= 11; t++) begin
            @(negedge clk);
            cmp_beat(t, len, col, ilv, wr, mk);
            cmd_valid = 1'b0;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        check(1'b0, "watchdog", 0, 1);
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        // R1 reset state
        repeat (3) @(negedge clk);
        check(beat_valid == 0 && beat_last == 0 && wr_rec_mark == 0, "R1 outputs in reset",
              {beat_valid, beat_last, wr_rec_mark}, 0);
        check(cmd_ready == 1, "R1 ready in reset", cmd_ready, 1);
        rst_n = 1'b1;
        @(negedge clk);
        check(beat_valid == 0 && wr_rec_mark == 0 && cmd_ready == 1, "R1 after release",
              {beat_valid, wr_rec_mark, cmd_ready}, 1);

        // Sweep: R2 R3 R4 R5 R6 R9 R10 R11
        for (int m = 0; m < 4; m++)
            for (int il = 0; il < 2; il++)
                for (int w = 0; w < 2; w++)
                    for (int c = 0; c < 2; c++)
                        for (int s = 0; s < 8; s++)
                            run_cmd(m[1:0], il[0], w[0], c[0], s);

        // R8 back-to-back: 8-beat sequential read from 3, then OTF chop interleaved from 2
        @(negedge clk);
        cfg_bmode = 2'b01; cfg_interleave = 1'b0;
        cmd_valid = 1'b1; cmd_write = 1'b0; cmd_chop = 1'b0; cmd_col = 3'd3;
        for (int t = 1; t <= 8; t++) begin
            @(negedge clk);
            cmd_valid = 1'b0;
            check(beat_col == exp_col(3, t - 1, 0, 0), "R8 first burst col", beat_col, exp_col(3, t - 1, 0, 0));
            if (t == 7) check(cmd_ready == 0, "R7 busy not ready", cmd_ready, 0);
            if (t == 8) begin
                check(cmd_ready == 1, "R7 ready on last", cmd_ready, 1);
                cfg_interleave = 1'b1; cmd_valid = 1'b1; cmd_chop = 1'b1; cmd_col = 3'd2;
            end
        end
        for (int t = 1; t <= 6; t++) begin
            @(negedge clk);
            cmd_valid = 1'b0;
            check(beat_valid == (t <= 4), "R8 second burst valid", beat_valid, t <= 4);
            if (t <= 4) check(beat_col == (2 ^ (t - 1)), "R8 second burst col", beat_col, 2 ^ (t - 1));
            check(beat_last == (t == 4), "R8 second burst last", beat_last, t == 4);
        end

        // R7 command while busy is ignored
        @(negedge clk);
        cfg_bmode = 2'b00; cfg_interleave = 1'b0;
        cmd_valid = 1'b1; cmd_write = 1'b0; cmd_col = 3'd0;
        @(negedge clk);
        cmd_valid = 1'b0;
        @(negedge clk);
        cmd_valid = 1'b1; cmd_write = 1'b1; cmd_col = 3'd5;
        check(cmd_ready == 0, "R7 refused while busy", cmd_ready, 0);
        for (int t = 3; t <= 12; t++) begin
            @(negedge clk);
            if (t == 3) cmd_valid = 1'b0;
            check(beat_valid == (t <= 8), "R7 ignored valid", beat_valid, t <= 8);
            if (t <= 8) check(beat_col == (t - 1), "R7 ignored col", beat_col, t - 1);
            check(wr_rec_mark == 0, "R7 ignored no mark", wr_rec_mark, 0);
        end

        // R12 configuration change during a burst
        @(negedge clk);
        cfg_bmode = 2'b00; cfg_interleave = 1'b1;
        cmd_valid = 1'b1; cmd_write = 1'b0; cmd_col = 3'd1;
        for (int t = 1; t <= 10; t++) begin
            @(negedge clk);
            cmd_valid = 1'b0;
            cfg_bmode = 2'b10; cfg_interleave = 1'b0;
            check(beat_valid == (t <= 8), "R12 length held", beat_valid, t <= 8);
            if (t <= 8) check(beat_col == (1 ^ (t - 1)), "R12 order held", beat_col, 1 ^ (t - 1));
        end

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule